// File: doc/BRIEF.md
# Reset Sequencer with Strap Sampling

This block produces the chip-wide active-low reset from two sources: an asynchronous active-low reset pin and a synchronous reset request raised by the watchdog. The pin drops the internal reset at once, with no clock needed. Its release is passed through a two-stage synchroniser, so the internal reset lifts on a clock edge.

While the pin is held low, two configuration straps are watched on every clock edge: the boot-width strap and the active-low tri-state strap. Each strap is latched low only when it was low on every one of the final ten edges before the pin is released. Otherwise it is latched high. A watchdog reset keeps these latched values.

The block also reports which source caused the last reset. It holds a remap flag that software sets with a write-one command. Any reset clears the remap flag.

Top module: `rstseq_top`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` is 0, `remap_on` is 0 and `cause_wdog` is 0. This holds from the moment the pin falls, with no clock edge needed.
- R2: After `ext_rst_n` rises, `sys_rst_n` stays 0 through the first rising clock edge. It becomes 1 after the second rising edge.
- R3: `boot_narrow` is 0 (16-bit boot device on chip select 0) only if `strap_boot` was 0 on each of the last 10 rising edges while `ext_rst_n` was low. Otherwise it is 1 (8-bit boot device).
- R4: `tristate_mode` is 1 only if `strap_tri_n` was 0 on each of the last 10 rising edges while `ext_rst_n` was low. Otherwise it is 0.
- R5: A pin reset that spans fewer than 10 rising edges gives `boot_narrow` = 1 and `tristate_mode` = 0, whatever the strap levels.
- R6: If `wdog_rst_req` is 1 at a rising edge while `sys_rst_n` is 1, then `sys_rst_n` is 0 from that edge on. It returns to 1 on the first edge that samples `wdog_rst_req` at 0.
- R7: `cause_wdog` becomes 1 on a watchdog reset. It becomes 0 on a pin reset.
- R8: Neither a watchdog reset nor a change of the strap inputs while `ext_rst_n` is high alters `boot_narrow` or `tristate_mode`.
- R9: A rising edge with `remap_wr` = 1, `remap_bit` = 1 and `sys_rst_n` = 1 sets `remap_on`. A write with `remap_bit` = 0 has no effect. A write while `sys_rst_n` is 0 has no effect.
- R10: Once set, `remap_on` stays 1 until a reset. Both a pin reset and a watchdog reset clear it.
- R11: The pin has priority over the watchdog. A `wdog_rst_req` that is high only while `ext_rst_n` is low, or before `sys_rst_n` has risen, neither sets `cause_wdog` nor lengthens the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous assertion |
| wdog_rst_req | input | 1 | Watchdog reset request, synchronous level |
| strap_boot | input | 1 | Boot-width strap, 1 = 8-bit, 0 = 16-bit |
| strap_tri_n | input | 1 | Tri-state strap, active low |
| remap_wr | input | 1 | Remap command write strobe |
| remap_bit | input | 1 | Remap command data bit; only a 1 acts |
| sys_rst_n | output | 1 | Internal system reset, active low |
| boot_narrow | output | 1 | Latched boot width, 1 = 8-bit |
| tristate_mode | output | 1 | Latched tri-state mode, 1 = outputs to be disabled |
| remap_on | output | 1 | Remap flag |
| cause_wdog | output | 1 | 1 if the last reset came from the watchdog |

## Verification
The assertions assume three things about the inputs:
- `ext_rst_n` is low at the first clock edge.
- Every synchronous input changes away from the rising edge.
- `wdog_rst_req` is a level that a correct design may see high for several cycles.

The bench starts with the pin low and drives every input on the falling edge. It releases the watchdog request before or right at the point where the reset should lift, so each expected value can be counted edge by edge from the requirements.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic {
    CAUSE_PIN  = 1'b0,
    CAUSE_WDOG = 1'b1
  } rst_cause_e;

  localparam int STRAP_BOOT = 0;
  localparam int STRAP_TRI  = 1;
  localparam int NUM_STRAPS = 2;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic released
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign released = chain_q[STAGES-1];

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!arst_n)
    chain_q[STAGES-1] |-> $past(chain_q[STAGES-2])); // R2
endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap #(
  parameter int WIN = 10
) (
  input  logic clk,
  input  logic sample_en,
  input  logic strap_in,
  output logic latched
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] run_q, run_d;
  logic          full_d;

  always_comb begin
    if (strap_in)                  run_d = '0;
    else if (run_q == CW'(WIN))    run_d = run_q;
    else                           run_d = run_q + 1'b1;
    full_d = (run_d == CW'(WIN));
  end

  always_ff @(posedge clk) begin
    if (sample_en) begin
      run_q   <= run_d;
      latched <= !full_d;
    end else begin
      run_q   <= '0;
    end
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_WIN   = 10
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic wdog_rst_req,
  input  logic strap_boot,
  input  logic strap_tri_n,
  input  logic remap_wr,
  input  logic remap_bit,
  output logic sys_rst_n,
  output logic boot_narrow,
  output logic tristate_mode,
  output logic remap_on,
  output logic cause_wdog
);
  import rstseq_pkg::*;

  logic                  pin_done;
  logic                  wd_hold_q;
  logic                  wd_accept;
  rst_cause_e            cause_q;
  logic                  remap_q;
  logic [NUM_STRAPS-1:0] strap_raw;
  logic [NUM_STRAPS-1:0] strap_lat;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst_n   (ext_rst_n),
    .released (pin_done)
  );

  assign strap_raw[STRAP_BOOT] = strap_boot;
  assign strap_raw[STRAP_TRI]  = strap_tri_n;

  for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_strap
    rstseq_strap #(.WIN(STRAP_WIN)) u_strap (
      .clk       (clk),
      .sample_en (!ext_rst_n),
      .strap_in  (strap_raw[g]),
      .latched   (strap_lat[g])
    );
  end

  // Watchdog only counts once the pin reset has fully released.
  assign wd_accept = wdog_rst_req && pin_done;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      wd_hold_q <= 1'b0;
      cause_q   <= CAUSE_PIN;
    end else begin
      wd_hold_q <= wd_accept;
      if (wd_accept) cause_q <= CAUSE_WDOG;
    end
  end

  assign sys_rst_n = pin_done && !wd_hold_q;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)                  remap_q <= 1'b0;
    else if (!sys_rst_n)             remap_q <= 1'b0;
    else if (remap_wr && remap_bit)  remap_q <= 1'b1;
  end

  assign remap_on      = remap_q;
  assign cause_wdog    = (cause_q == CAUSE_WDOG);
  assign boot_narrow   = strap_lat[STRAP_BOOT];
  assign tristate_mode = !strap_lat[STRAP_TRI];

  AST_WDOG_ENTERS: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdog_rst_req && sys_rst_n) |=> !sys_rst_n); // R6
  AST_WDOG_CAUSE: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdog_rst_req && sys_rst_n) |=> cause_wdog); // R7
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $past(ext_rst_n) |-> ($stable(boot_narrow) && $stable(tristate_mode))); // R8
  AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!ext_rst_n)
    ($past(sys_rst_n) && $past(remap_on)) |-> remap_on); // R10
  AST_REMAP_CLEARED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !sys_rst_n |=> !remap_on); // R10
  AST_PIN_FIRST: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) && !$past(wd_hold_q) |-> !cause_wdog); // R11
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic wdog_rst_req = 1'b0;
  logic strap_boot = 1'b1;
  logic strap_tri_n = 1'b1;
  logic remap_wr = 1'b0;
  logic remap_bit = 1'b0;
  logic sys_rst_n, boot_narrow, tristate_mode, remap_on, cause_wdog;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rstseq_top uut (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_rst_req(wdog_rst_req),
    .strap_boot(strap_boot), .strap_tri_n(strap_tri_n),
    .remap_wr(remap_wr), .remap_bit(remap_bit),
    .sys_rst_n(sys_rst_n), .boot_narrow(boot_narrow),
    .tristate_mode(tristate_mode), .remap_on(remap_on), .cause_wdog(cause_wdog)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Pin reset spanning len edges; each strap low on its final kb / kt edges.
  task automatic pin_reset(input int len, input int kb, input int kt);
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    chk("R1 sys_rst_n", sys_rst_n, 1'b0);
    chk("R1 remap_on", remap_on, 1'b0);
    chk("R1 cause_wdog", cause_wdog, 1'b0);
    for (int i = 0; i < len; i++) begin
      strap_boot  = (i >= len - kb) ? 1'b0 : 1'b1;
      strap_tri_n = (i >= len - kt) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    ext_rst_n   = 1'b1;
    strap_boot  = ~strap_boot;   // R8: ignored after release
    strap_tri_n = ~strap_tri_n;
    @(negedge clk);
    chk("R2 held after edge 1", sys_rst_n, 1'b0);
    @(negedge clk);
    chk("R2 released after edge 2", sys_rst_n, 1'b1);
    strap_boot = 1'b0; strap_tri_n = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset state", sys_rst_n, 1'b0);
    repeat (3) @(negedge clk);

    // Sweep: boot strap low for k final edges, tri strap low for 12-k.
    for (int k = 0; k <= 12; k++) begin
      pin_reset(14, k, 12 - k);
      chk("R3 boot_narrow", boot_narrow, (k >= 10) ? 1'b0 : 1'b1);
      chk("R4 tristate_mode", tristate_mode, ((12 - k) >= 10) ? 1'b1 : 1'b0);
      repeat (3) @(negedge clk);
      chk("R8 straps ignored while released", boot_narrow, (k >= 10) ? 1'b0 : 1'b1);
      chk("R7 pin cause", cause_wdog, 1'b0);
    end

    // Short resets.
    pin_reset(5, 5, 5);
    chk("R5 boot_narrow short", boot_narrow, 1'b1);
    chk("R5 tristate_mode short", tristate_mode, 1'b0);
    pin_reset(9, 9, 9);
    chk("R5 boot_narrow 9 edges", boot_narrow, 1'b1);
    chk("R5 tristate_mode 9 edges", tristate_mode, 1'b0);
    pin_reset(10, 10, 10);
    chk("R3 boundary 10 edges", boot_narrow, 1'b0);
    chk("R4 boundary 10 edges", tristate_mode, 1'b1);

    // Remap commands.
    remap_wr = 1'b1; remap_bit = 1'b0;
    @(negedge clk);
    chk("R9 write zero no effect", remap_on, 1'b0);
    remap_bit = 1'b1;
    @(negedge clk);
    remap_wr = 1'b0; remap_bit = 1'b0;
    chk("R9 write one sets", remap_on, 1'b1);
    remap_wr = 1'b1;
    @(negedge clk);
    remap_wr = 1'b0;
    chk("R10 sticky after zero write", remap_on, 1'b1);

    // Watchdog reset.
    wdog_rst_req = 1'b1;
    @(negedge clk);
    chk("R6 wdog asserts reset", sys_rst_n, 1'b0);
    chk("R7 wdog cause", cause_wdog, 1'b1);
    remap_wr = 1'b1; remap_bit = 1'b1;
    @(negedge clk);
    chk("R10 wdog clears remap", remap_on, 1'b0);
    @(negedge clk);
    chk("R9 write during reset ignored", remap_on, 1'b0);
    remap_wr = 1'b0; remap_bit = 1'b0;
    wdog_rst_req = 1'b0;
    chk("R6 still held", sys_rst_n, 1'b0);
    @(negedge clk);
    chk("R6 released", sys_rst_n, 1'b1);
    chk("R8 boot kept after wdog", boot_narrow, 1'b0);
    chk("R8 tri kept after wdog", tristate_mode, 1'b1);
    chk("R7 cause held", cause_wdog, 1'b1);

    // Priority: request only during pin reset and synchroniser.
    @(negedge clk);
    ext_rst_n = 1'b0;
    wdog_rst_req = 1'b1;
    #1;
    chk("R1 pin clears cause", cause_wdog, 1'b0);
    repeat (4) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wdog_rst_req = 1'b0;
    chk("R11 pin release not extended", sys_rst_n, 1'b1);
    @(negedge clk);
    chk("R11 cause stays pin", cause_wdog, 1'b0);
    chk("R11 still released", sys_rst_n, 1'b1);
    chk("R5 short reset under wdog", boot_narrow, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule